// File: doc/BRIEF.md
# Vertical Interval Line Counter with Gun Calibration Sequencer

This block sits after the level slicer of a three-level sandcastle input. It receives three digital levels: the vertical blanking level, the horizontal pulse and the burst (clamp) pulse. From these it counts lines inside each vertical interval. It rebuilds a composite blanking signal whose vertical part always lasts a fixed number of lines, however long the incoming vertical level stays high.

Inside that regenerated vertical part, the block runs a fixed calibration schedule for the three picture-tube guns. The schedule occupies lines 17 to 23. Green, red and blue each get a drive pulse on one line. A blank line follows, on which leakage is measured. Then green, red and blue each get a quasi cut-off pulse. The block also issues a per-channel sample enable for the analog memories, a leakage sample enable and a measurement-range select. An input vertical level that is too short is reported on a flag.

The control core is a three-state machine. SEQ_IDLE is the state after reset. SEQ_VERT counts lines 1 to 23. SEQ_TRACE covers the rest of the field. The transitions are named as follows:
- VB_START: a rising edge of vertical blanking, from any state, goes to SEQ_VERT on line 1.
- LINE_STEP: a rising horizontal edge in SEQ_VERT below line 23 moves to the next line.
- VB_END: a rising horizontal edge on line 23 goes to SEQ_TRACE.

Top module: `sandcastle_cal_seq`

## Requirements
- R1: A rising edge of `sc_vblank_i` sets the line number to 1. Each later rising edge of `sc_hpulse_i` advances it by one. Line n therefore starts with the n-th horizontal pulse counted from the one at which vertical blanking rose.
- R2: `vert_blank_o` is high for lines 1 to 23 exactly and low from line 24 on. This holds whether the input vertical level is shorter or longer than 23 lines.
- R3: `comp_blank_o` equals `vert_blank_o` OR `sc_hpulse_i` OR `sc_burst_i`.
- R4: Channel bit order for all three-bit outputs is bit 0 red, bit 1 green, bit 2 blue. `drive_ins_o` is 3'b010 on line 17, 3'b001 on line 18 and 3'b100 on line 19.
- R5: On line 20, `leak_smp_o` is asserted and `chan_blank_o` is high for the whole line. `chan_blank_o` is low on every other line.
- R6: `cut_ins_o` is 3'b010 on line 21, 3'b001 on line 22 and 3'b100 on line 23.
- R7: `range_sel_o` is high for the whole of lines 17, 18 and 19, and low otherwise.
- R8: `drive_ins_o`, `cut_ins_o`, `leak_smp_o` and `smp_ch_o` are asserted only when three conditions hold: `sc_hpulse_i` is low, `sc_burst_i` is low, and a horizontal pulse has ended since the last one began.
- R9: `smp_ch_o[c]` is asserted on the drive line and on the cut-off line of channel c. Across `smp_ch_o` and `leak_smp_o`, at most one bit is high at any time.
- R10: On a falling edge of `sc_vblank_i`, `vb_short_o` becomes 1 if the input vertical level lasted 11 lines or fewer, and 0 if it lasted 12 lines or more.
- R11: A new rising edge of `sc_vblank_i` at any point, including within the calibration lines, restarts the count at line 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sc_vblank_i | input | 1 | Sliced vertical blanking level |
| sc_hpulse_i | input | 1 | Sliced horizontal pulse level |
| sc_burst_i | input | 1 | Sliced burst/clamp pulse level |
| comp_blank_o | output | 1 | Regenerated composite blanking |
| vert_blank_o | output | 1 | Fixed-length vertical blanking part |
| drive_ins_o | output | 3 | Drive pulse insertion per channel (R,G,B = bit 0,1,2) |
| leak_smp_o | output | 1 | Leakage sample enable |
| chan_blank_o | output | 1 | Blank all three channels (leakage line) |
| cut_ins_o | output | 3 | Quasi cut-off pulse insertion per channel |
| range_sel_o | output | 1 | Measurement range select for drive lines |
| smp_ch_o | output | 3 | Per-channel sample enable for drive/cut-off memories |
| vb_short_o | output | 1 | Last input vertical level was too short |

## Verification
The assertions take the three inputs to be clean, clock-synchronous levels. They assume a horizontal pulse lasts at least one clock and that burst never overlaps the horizontal pulse. The stimulus builds every line as horizontal pulse, then burst, then active video, with changes only on the falling clock edge. Vertical blanking changes only at the cycle in which a horizontal pulse starts, so line boundaries match the requirements exactly. Within that discipline, the tests vary the input vertical length: below, at and above the 11/12-line limit, and above 23 lines. They also raise vertical blanking again in the middle of the calibration lines.

// File: rtl/sc_cal_pkg.sv
package sc_cal_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_VERT  = 2'd1,
        SEQ_TRACE = 2'd2
    } seq_state_e;

    localparam int NUM_CH = 3;
    localparam int CH_RED = 0;
    localparam int CH_GRN = 1;
    localparam int CH_BLU = 2;

    // measurement order within each group of calibration lines
    function automatic int seq_chan(input int step);
        case (step)
            0:       return CH_GRN;
            1:       return CH_RED;
            default: return CH_BLU;
        endcase
    endfunction

endpackage

// File: rtl/sc_edge_det.sv
module sc_edge_det #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    logic [W-1:0] lvl_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_i;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rise_o[i] =  lvl_i[i] & ~lvl_q[i];
        assign fall_o[i] = ~lvl_i[i] &  lvl_q[i];
    end
endmodule

// File: rtl/sc_line_fsm.sv
module sc_line_fsm
    import sc_cal_pkg::*;
#(
    parameter int VB_LINES = 23,
    parameter int MIN_VB   = 11,
    parameter int LINE_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vb_rise,
    input  logic              vb_fall,
    input  logic              hp_rise,
    input  logic              hp_fall,
    output logic [LINE_W-1:0] line_o,
    output logic              in_vert_o,
    output logic              line_act_o,
    output logic              vb_short_o
);
    localparam logic [LINE_W-1:0] LAST_L  = LINE_W'(VB_LINES);
    localparam logic [LINE_W-1:0] MIN_L   = LINE_W'(MIN_VB);
    localparam logic [LINE_W-1:0] FIRST_L = LINE_W'(1);

    seq_state_e        state_q, state_d;
    logic [LINE_W-1:0] line_q, line_d;
    logic              act_q, short_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            line_q  <= '0;
        end else begin
            state_q <= state_d;
            line_q  <= line_d;
        end
    end

    always_comb begin
        state_d = state_q;
        line_d  = line_q;
        unique case (state_q)
            SEQ_IDLE: line_d = '0;
            SEQ_VERT: begin
                if (hp_rise) begin
                    if (line_q == LAST_L) begin       // VB_END
                        state_d = SEQ_TRACE;
                        line_d  = '0;
                    end else begin                    // LINE_STEP
                        line_d = line_q + FIRST_L;
                    end
                end
            end
            SEQ_TRACE: line_d = '0;
            default: begin
                state_d = SEQ_IDLE;
                line_d  = '0;
            end
        endcase
        if (vb_rise) begin                            // VB_START
            state_d = SEQ_VERT;
            line_d  = FIRST_L;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q   <= 1'b0;
            short_q <= 1'b0;
        end else begin
            if (hp_rise)      act_q <= 1'b0;
            else if (hp_fall) act_q <= 1'b1;
            if (vb_fall)
                short_q <= (state_q == SEQ_VERT) && (line_q <= MIN_L);
        end
    end

    assign line_o     = line_q;
    assign in_vert_o  = (state_q == SEQ_VERT);
    assign line_act_o = act_q;
    assign vb_short_o = short_q;

    assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        vb_rise |=> (line_q == FIRST_L && state_q == SEQ_VERT));

    assert_advance_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_VERT && hp_rise && !vb_rise && line_q != LAST_L)
        |=> (line_q == $past(line_q) + FIRST_L));

    assert_line_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_VERT) |-> (line_q >= FIRST_L && line_q <= LAST_L));
endmodule

// File: rtl/sc_cal_decode.sv
module sc_cal_decode
    import sc_cal_pkg::*;
#(
    parameter int LINE_W    = 5,
    parameter int CAL_FIRST = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] line_i,
    input  logic              in_vert_i,
    input  logic              active_i,
    output logic [2:0]        drive_ins_o,
    output logic [2:0]        cut_ins_o,
    output logic [2:0]        smp_ch_o,
    output logic              leak_smp_o,
    output logic              chan_blank_o,
    output logic              range_sel_o
);
    localparam logic [LINE_W-1:0] DRV_LO  = LINE_W'(CAL_FIRST);
    localparam logic [LINE_W-1:0] DRV_HI  = LINE_W'(CAL_FIRST + NUM_CH - 1);
    localparam logic [LINE_W-1:0] LEAK_L  = LINE_W'(CAL_FIRST + NUM_CH);

    logic gate;
    assign gate = in_vert_i & active_i;

    for (genvar s = 0; s < NUM_CH; s++) begin : g_step
        localparam int CH = seq_chan(s);
        localparam logic [LINE_W-1:0] DRV_L = LINE_W'(CAL_FIRST + s);
        localparam logic [LINE_W-1:0] CUT_L = LINE_W'(CAL_FIRST + NUM_CH + 1 + s);
        assign drive_ins_o[CH] = gate & (line_i == DRV_L);
        assign cut_ins_o[CH]   = gate & (line_i == CUT_L);
        assign smp_ch_o[CH]    = gate & ((line_i == DRV_L) | (line_i == CUT_L));
    end

    assign chan_blank_o = in_vert_i & (line_i == LEAK_L);
    assign leak_smp_o   = gate & (line_i == LEAK_L);
    assign range_sel_o  = in_vert_i & (line_i >= DRV_LO) & (line_i <= DRV_HI);

    assert_onehot_smp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({smp_ch_o, leak_smp_o}));

    assert_range_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        range_sel_o |-> (cut_ins_o == 3'b000 && !leak_smp_o && !chan_blank_o));
endmodule

// File: rtl/sandcastle_cal_seq.sv
module sandcastle_cal_seq #(
    parameter int VB_LINES  = 23,
    parameter int MIN_VB    = 11,
    parameter int CAL_FIRST = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sc_vblank_i,
    input  logic       sc_hpulse_i,
    input  logic       sc_burst_i,
    output logic       comp_blank_o,
    output logic       vert_blank_o,
    output logic [2:0] drive_ins_o,
    output logic       leak_smp_o,
    output logic       chan_blank_o,
    output logic [2:0] cut_ins_o,
    output logic       range_sel_o,
    output logic [2:0] smp_ch_o,
    output logic       vb_short_o
);
    localparam int LINE_W = $clog2(VB_LINES + 1);

    logic [1:0]        rise, fall;
    logic [LINE_W-1:0] line;
    logic              in_vert, line_act, active;

    sc_edge_det #(.W(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  ({sc_hpulse_i, sc_vblank_i}),
        .rise_o (rise),
        .fall_o (fall)
    );

    sc_line_fsm #(.VB_LINES(VB_LINES), .MIN_VB(MIN_VB), .LINE_W(LINE_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .vb_rise    (rise[0]),
        .vb_fall    (fall[0]),
        .hp_rise    (rise[1]),
        .hp_fall    (fall[1]),
        .line_o     (line),
        .in_vert_o  (in_vert),
        .line_act_o (line_act),
        .vb_short_o (vb_short_o)
    );

    assign active = line_act & ~sc_hpulse_i & ~sc_burst_i;

    sc_cal_decode #(.LINE_W(LINE_W), .CAL_FIRST(CAL_FIRST)) u_dec (
        .clk          (clk),
        .rst_n        (rst_n),
        .line_i       (line),
        .in_vert_i    (in_vert),
        .active_i     (active),
        .drive_ins_o  (drive_ins_o),
        .cut_ins_o    (cut_ins_o),
        .smp_ch_o     (smp_ch_o),
        .leak_smp_o   (leak_smp_o),
        .chan_blank_o (chan_blank_o),
        .range_sel_o  (range_sel_o)
    );

    assign vert_blank_o = in_vert;
    assign comp_blank_o = in_vert | sc_hpulse_i | sc_burst_i;

    assert_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_hpulse_i || sc_burst_i)
        |-> ({drive_ins_o, cut_ins_o, smp_ch_o, leak_smp_o} == 10'd0));

    assert_comp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_hpulse_i || sc_burst_i || vert_blank_o) |-> comp_blank_o);
endmodule

// File: tb/sandcastle_cal_seq_tb.sv
module sandcastle_cal_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       vb = 1'b0, hp = 1'b0, bu = 1'b0;
    logic       comp_blank, vert_blank, leak_smp, chan_blank, range_sel, vb_short;
    logic [2:0] drive_ins, cut_ins, smp_ch;

    int checks = 0;
    int fails  = 0;

    // bench model state
    int exp_n     = 0;
    int vb_run    = 0;
    bit vb_prev   = 1'b0;
    bit exp_short = 1'b0;

    localparam int HP_CYC  = 3;
    localparam int BU_CYC  = 2;
    localparam int ACT_CYC = 8;

    always #5 clk = ~clk;

    sandcastle_cal_seq u_dut (
        .clk(clk), .rst_n(rst_n),
        .sc_vblank_i(vb), .sc_hpulse_i(hp), .sc_burst_i(bu),
        .comp_blank_o(comp_blank), .vert_blank_o(vert_blank),
        .drive_ins_o(drive_ins), .leak_smp_o(leak_smp), .chan_blank_o(chan_blank),
        .cut_ins_o(cut_ins), .range_sel_o(range_sel), .smp_ch_o(smp_ch),
        .vb_short_o(vb_short)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s line=%0d act=%0h exp=%0h t=%0t", req, exp_n, act, exp, $time);
        end
    endtask

    function automatic logic [2:0] chan_bit(input int step);
        case (step)
            0:       return 3'b010;
            1:       return 3'b001;
            default: return 3'b100;
        endcase
    endfunction

    function automatic logic [2:0] exp_drv(input int n);
        return (n >= 17 && n <= 19) ? chan_bit(n - 17) : 3'b000;
    endfunction

    function automatic logic [2:0] exp_cut(input int n);
        return (n >= 21 && n <= 23) ? chan_bit(n - 21) : 3'b000;
    endfunction

    task automatic cyc(input logic h, input logic b, input logic v);
        @(negedge clk);
        hp = h; bu = b; vb = v;
        @(posedge clk);
        #1;
    endtask

    // one full line; vertical level changes only at the line start
    task automatic run_line(input bit v);
        bit vert;
        if (v && !vb_prev) begin
            exp_n = 1; vb_run = 1;
        end else begin
            if (exp_n >= 1 && exp_n < 23) exp_n++;
            else exp_n = 0;
            if (v) vb_run++;
        end
        if (!v && vb_prev) exp_short = (vb_run <= 11);
        vb_prev = v;
        vert = (exp_n >= 1);
        for (int c = 0; c < HP_CYC + BU_CYC + ACT_CYC; c++) begin
            cyc(c < HP_CYC, (c >= HP_CYC) && (c < HP_CYC + BU_CYC), v);
            if (c == 1) begin
                chk(comp_blank == 1'b1, "R3 hpulse", comp_blank, 1);
                chk({drive_ins, cut_ins, smp_ch, leak_smp} == 10'd0, "R8 gate hp",
                    {drive_ins, cut_ins, smp_ch, leak_smp}, 0);
                chk(range_sel == (exp_n >= 17 && exp_n <= 19), "R7 range hp",
                    range_sel, (exp_n >= 17 && exp_n <= 19));
                chk(chan_blank == (exp_n == 20), "R5 blank hp", chan_blank, (exp_n == 20));
            end
            if (c == HP_CYC) begin
                chk({drive_ins, cut_ins, smp_ch, leak_smp} == 10'd0, "R8 gate burst",
                    {drive_ins, cut_ins, smp_ch, leak_smp}, 0);
            end
            if (c == HP_CYC + BU_CYC + 3) begin
                chk(vert_blank == vert, "R2 vert", vert_blank, vert);
                chk(comp_blank == vert, "R3 active", comp_blank, vert);
                chk(drive_ins == exp_drv(exp_n), "R4 drive", drive_ins, exp_drv(exp_n));
                chk(cut_ins == exp_cut(exp_n), "R6 cut", cut_ins, exp_cut(exp_n));
                chk(leak_smp == (exp_n == 20), "R5 leak", leak_smp, (exp_n == 20));
                chk(chan_blank == (exp_n == 20), "R5 blank", chan_blank, (exp_n == 20));
                chk(range_sel == (exp_n >= 17 && exp_n <= 19), "R7 range",
                    range_sel, (exp_n >= 17 && exp_n <= 19));
                chk(smp_ch == (exp_drv(exp_n) | exp_cut(exp_n)), "R9 smp",
                    smp_ch, exp_drv(exp_n) | exp_cut(exp_n));
                chk(vb_short == exp_short, "R10 short", vb_short, exp_short);
            end
        end
    endtask

    task automatic run_field(input int vb_lines, input int total);
        for (int l = 0; l < total; l++) run_line(l < vb_lines);
    endtask

    task automatic t_reset;
        chk({comp_blank, vert_blank, drive_ins, cut_ins, smp_ch, leak_smp,
             chan_blank, range_sel, vb_short} == 15'd0, "R1 reset state",
            {comp_blank, vert_blank, drive_ins, cut_ins, smp_ch, leak_smp,
             chan_blank, range_sel, vb_short}, 0);
    endtask

    // R1 R2 R4 R5 R6 R7 R8 R9: nominal field with a 15-line vertical level
    task automatic t_nominal;
        run_field(15, 28);
    endtask

    // R10 boundary: 8 and 11 lines flagged, 12 lines accepted
    task automatic t_short;
        run_field(8, 26);
        run_field(11, 26);
        run_field(12, 26);
    endtask

    // R2: input vertical level longer than the regenerated part
    task automatic t_long;
        run_field(30, 34);
    endtask

    // R11: vertical level rises again during the calibration lines
    task automatic t_restart;
        run_field(14, 18);
        run_field(14, 28);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=0 exp=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset;
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        t_reset;
        run_field(0, 2);
        t_nominal;
        t_short;
        t_long;
        t_restart;
        run_field(0, 2);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule